// File: doc/BRIEF.md
# Flash Self-Programming Controller

This block sits between a processor and an on-chip flash array and turns a small control/status byte, plus a strobe from the program-store instruction, into flash commands. Software first writes the byte to arm an operation: program enable, with at most one function bit for erase, write, lock-bit set or section re-enable. It then executes the program-store instruction within a short window. The block sends a one-hot command to the flash model and holds it until the model answers by raising busy. Program enable stays set until the model drops busy again.

The block also tracks whether the read-while-write section of the flash is unavailable. An erase or page write marks the section busy, and reads of it are refused. The section comes back after an explicit re-enable operation, or as a side effect of a page load. Writing the re-enable bit while the page buffer holds loaded data discards that data. A ready interrupt is raised whenever the interrupt enable bit and the global interrupt flag are set and no operation is pending.

Top module: `fspm_ctrl`

## Requirements
- R1: The control byte reads bit 7 interrupt enable (read/write), bit 6 section busy (read-only), bit 5 reserved, bit 4 section re-enable, bit 3 lock-bit set, bit 2 page write, bit 1 page erase, bit 0 program enable. All bits are 0 after reset.
- R2: Bit 5 always reads 0. Writes to bit 5 and bit 6 have no effect.
- R3: A write made while no operation is pending, with bit 0 set and at most one of bits 4..1 set, arms a command. A strobe on any of the four clock edges after the write starts it. If no strobe comes, bits 4..0 read 0 after the fourth edge, and a later strobe issues nothing.
- R4: A write with bit 0 clear, or with more than one of bits 4..1 set, leaves bits 4..0 at 0 and arms nothing.
- R5: On an accepted strobe, `flash_cmd` becomes one-hot on the next edge: bit 0 page load (no function bit), bit 1 erase, bit 2 page write, bit 3 lock-bit set. It is held unchanged while `flash_busy` is low, and it is 0 the cycle after `flash_busy` is sampled high.
- R6: From arming until `flash_busy` falls after an issued command, bits 4..0 keep their armed value and writes to them are ignored. A re-enable written during an erase therefore has no effect. Bits 4..0 read 0 the cycle after `flash_busy` falls.
- R7: Issuing an erase or page write sets bit 6. While bit 6 is set, `rww_rd_grant` stays low even when `rww_rd_req` is high. Otherwise `rww_rd_grant` follows `rww_rd_req`.
- R8: An armed re-enable (value 0x11 in bits 4..0) followed by a strobe clears bit 6. It sends no flash command and clears bits 4..0.
- R9: Issuing a page load clears bit 6 on the same edge.
- R10: A write with bit 4 set, while no operation is pending and the page buffer holds data (a page load issued since the last page write), raises `buf_discard` for exactly one cycle and empties the buffer. Any other write leaves `buf_discard` low.
- R11: `irq` is high exactly when bit 7, `gie` and not bit 0 all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Control/status byte readback |
| spm_strobe | input | 1 | Program-store instruction executed this cycle |
| gie | input | 1 | Global interrupt enable from the processor |
| flash_busy | input | 1 | Flash model busy/acknowledge |
| flash_cmd | output | 4 | One-hot command to the flash model |
| buf_discard | output | 1 | One-cycle pulse: drop page buffer contents |
| rww_rd_req | input | 1 | Read request to the read-while-write section |
| rww_rd_grant | output | 1 | Read permitted |
| irq | output | 1 | Ready interrupt request |

## Verification
The command path is tried with each function pattern in turn: bare program enable, erase, page write, lock-bit set and re-enable. This separates the one-hot encodings and shows which of them touch the section busy flag and the buffer state. The strobe is placed on the last edge of the window, and also one edge after it, which pins down the four-edge limit. Writes with two function bits and writes without program enable are shown to arm nothing. Re-enable writes are made during an operation, after completion, with a loaded buffer and with an empty one; these separate refusal, clearing and load abort.

// File: rtl/fspm_pkg.sv
package fspm_pkg;

    localparam int CSR_W   = 8;
    localparam int CMD_W   = 4;
    localparam int FUNC_W  = 5;

    localparam int BIT_IE   = 7;
    localparam int BIT_BUSY = 6;
    localparam int BIT_PEN  = 0;

    localparam int CMD_LOAD  = 0;
    localparam int CMD_ERASE = 1;
    localparam int CMD_WRITE = 2;
    localparam int CMD_LOCK  = 3;

    localparam logic [CSR_W-1:0] KEEP_ALL = 8'h9F;
    localparam logic [CSR_W-1:0] KEEP_IE  = 8'h80;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_ISSUE,
        ST_BUSY
    } fspm_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_ERASE,
        OP_WRITE,
        OP_LOCK,
        OP_REEN
    } fspm_op_e;

    typedef struct packed {
        fspm_state_e      st;
        fspm_op_e         op;
        logic [CSR_W-1:0] csr;
        logic             rww_busy;
        logic             buf_full;
        logic             discard;
        logic [CMD_W-1:0] cmd;
    } fspm_regs_t;

endpackage

// File: rtl/fspm_cmd_dec.sv
module fspm_cmd_dec
    import fspm_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output logic              arm_ok,
    output fspm_op_e          op
);

    localparam int NFN = FUNC_W - 1;

    logic [NFN-1:0] fn;
    assign fn = func[FUNC_W-1:1];

    always_comb begin
        arm_ok = func[0] && ($countones(fn) <= 1);
        op     = OP_NONE;
        if (arm_ok) begin
            op = OP_LOAD;
            for (int i = 0; i < NFN; i++) begin
                if (fn[i]) begin
                    unique case (i)
                        0:       op = OP_ERASE;
                        1:       op = OP_WRITE;
                        2:       op = OP_LOCK;
                        default: op = OP_REEN;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/fspm_arm_timer.sv
module fspm_arm_timer #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = (WIN > 2) ? $clog2(WIN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = '0;
        end else if (run && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    assign expire = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/fspm_out_gate.sv
module fspm_out_gate (
    input  logic rww_busy,
    input  logic rd_req,
    input  logic ie,
    input  logic gie,
    input  logic pen,
    output logic rd_grant,
    output logic irq
);

    assign rd_grant = rd_req && !rww_busy;
    assign irq      = ie && gie && !pen;

endmodule

// File: rtl/fspm_ctrl.sv
module fspm_ctrl
    import fspm_pkg::*;
#(
    parameter int ARM_WIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [CSR_W-1:0] reg_wdata,
    output logic [CSR_W-1:0] reg_rdata,
    input  logic             spm_strobe,
    input  logic             gie,
    input  logic             flash_busy,
    output logic [CMD_W-1:0] flash_cmd,
    output logic             buf_discard,
    input  logic             rww_rd_req,
    output logic             rww_rd_grant,
    output logic             irq
);

    fspm_regs_t d, q;

    logic     wr_arm_ok;
    fspm_op_e wr_op;
    logic     tmr_start;
    logic     tmr_run;
    logic     tmr_expire;

    fspm_cmd_dec u_dec (
        .func   (reg_wdata[FUNC_W-1:0]),
        .arm_ok (wr_arm_ok),
        .op     (wr_op)
    );

    assign tmr_start = reg_we && (q.st == ST_IDLE) && wr_arm_ok;
    assign tmr_run   = (q.st == ST_ARMED) && !spm_strobe;

    fspm_arm_timer #(.WIN(ARM_WIN)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .run    (tmr_run),
        .expire (tmr_expire)
    );

    always_comb begin
        d         = q;
        d.discard = 1'b0;

        if (reg_we) begin
            if (q.st == ST_IDLE) begin
                d.csr = reg_wdata & (wr_arm_ok ? KEEP_ALL : KEEP_IE);
                if (reg_wdata[4] && q.buf_full) begin
                    d.discard  = 1'b1;
                    d.buf_full = 1'b0;
                end
                if (wr_arm_ok) begin
                    d.st = ST_ARMED;
                    d.op = wr_op;
                end
            end else begin
                d.csr[BIT_IE] = reg_wdata[BIT_IE];
            end
        end

        unique case (q.st)
            ST_ARMED: begin
                if (spm_strobe) begin
                    d.st = ST_ISSUE;
                    unique case (q.op)
                        OP_LOAD: begin
                            d.cmd[CMD_LOAD] = 1'b1;
                            d.rww_busy      = 1'b0;
                            d.buf_full      = 1'b1;
                        end
                        OP_ERASE: begin
                            d.cmd[CMD_ERASE] = 1'b1;
                            d.rww_busy       = 1'b1;
                        end
                        OP_WRITE: begin
                            d.cmd[CMD_WRITE] = 1'b1;
                            d.rww_busy       = 1'b1;
                            d.buf_full       = 1'b0;
                        end
                        OP_LOCK: begin
                            d.cmd[CMD_LOCK] = 1'b1;
                        end
                        default: begin
                            d.rww_busy = 1'b0;
                            d.csr      = q.csr & KEEP_IE;
                            d.st       = ST_IDLE;
                        end
                    endcase
                end else if (tmr_expire) begin
                    d.csr = q.csr & KEEP_IE;
                    d.st  = ST_IDLE;
                end
            end
            ST_ISSUE: begin
                if (flash_busy) begin
                    d.cmd = '0;
                    d.st  = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (!flash_busy) begin
                    d.csr = d.csr & KEEP_IE;
                    d.st  = ST_IDLE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, op: OP_NONE, csr: '0, rww_busy: 1'b0,
                   buf_full: 1'b0, discard: 1'b0, cmd: '0};
        end else begin
            q <= d;
        end
    end

    assign reg_rdata   = q.csr | (CSR_W'(q.rww_busy) << BIT_BUSY);
    assign flash_cmd   = q.cmd;
    assign buf_discard = q.discard;

    fspm_out_gate u_gate (
        .rww_busy (q.rww_busy),
        .rd_req   (rww_rd_req),
        .ie       (q.csr[BIT_IE]),
        .gie      (gie),
        .pen      (q.csr[BIT_PEN]),
        .rd_grant (rww_rd_grant),
        .irq      (irq)
    );

endmodule

// File: rtl/fspm_ctrl_chk.sv
module fspm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_rdata,
    input logic [3:0] flash_cmd,
    input logic       flash_busy,
    input logic       buf_discard,
    input logic       rww_rd_req,
    input logic       rww_rd_grant,
    input logic       gie,
    input logic       irq
);

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flash_cmd)); // R5

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_cmd != 4'd0 && !flash_busy) |=> $stable(flash_cmd)); // R5

    AST_CMD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_cmd != 4'd0 && flash_busy) |=> (flash_cmd == 4'd0)); // R5

    AST_CMD_PEN: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_cmd != 4'd0) |-> reg_rdata[0]); // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[5]); // R2

    AST_GRANT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (rww_rd_req && reg_rdata[6]) |-> !rww_rd_grant); // R7

    AST_DISCARD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_discard |=> !buf_discard); // R10

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!reg_rdata[0] && reg_rdata[7] && gie)); // R11

endmodule

bind fspm_ctrl fspm_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_rdata    (reg_rdata),
    .flash_cmd    (flash_cmd),
    .flash_busy   (flash_busy),
    .buf_discard  (buf_discard),
    .rww_rd_req   (rww_rd_req),
    .rww_rd_grant (rww_rd_grant),
    .gie          (gie),
    .irq          (irq)
);

// File: tb/fspm_ctrl_tb_top.sv
module fspm_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spm_strobe = 1'b0;
    logic       gie = 1'b0;
    logic       flash_busy = 1'b0;
    logic [3:0] flash_cmd;
    logic       buf_discard;
    logic       rww_rd_req = 1'b1;
    logic       rww_rd_grant;
    logic       irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    fspm_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .spm_strobe   (spm_strobe),
        .gie          (gie),
        .flash_busy   (flash_busy),
        .flash_cmd    (flash_cmd),
        .buf_discard  (buf_discard),
        .rww_rd_req   (rww_rd_req),
        .rww_rd_grant (rww_rd_grant),
        .irq          (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [7:0] v);
        reg_we    = 1'b1;
        reg_wdata = v;
        tick();
        reg_we    = 1'b0;
    endtask

    task automatic strobe();
        spm_strobe = 1'b1;
        tick();
        spm_strobe = 1'b0;
    endtask

    task automatic ack();
        flash_busy = 1'b1;
        tick();
        flash_busy = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 reset byte", reg_rdata, 8'h00);
        chk("R5 reset cmd", flash_cmd, 4'h0);
        chk("R11 reset irq", irq, 1'b0);
        chk("R10 reset discard", buf_discard, 1'b0);
        chk("R7 reset grant", rww_rd_grant, 1'b1);
    endtask

    task automatic t_layout();
        wr(8'hA0);
        chk("R2 bit5 ignored", reg_rdata, 8'h80);
        wr(8'hC0);
        chk("R2 bit6 ignored", reg_rdata, 8'h80);
        wr(8'h00);
        chk("R1 ie cleared", reg_rdata, 8'h00);
    endtask

    task automatic t_invalid();
        wr(8'h07);
        chk("R4 two function bits", reg_rdata, 8'h00);
        strobe();
        chk("R4 no cmd", flash_cmd, 4'h0);
        wr(8'h04);
        chk("R4 no enable", reg_rdata, 8'h00);
        strobe();
        chk("R4 no cmd without enable", flash_cmd, 4'h0);
    endtask

    task automatic t_window();
        wr(8'h01);
        chk("R3 armed readback", reg_rdata, 8'h01);
        idle(3);
        strobe();
        chk("R3 strobe on 4th edge issues load", flash_cmd, 4'b0001);
        ack();
        chk("R6 load complete", reg_rdata, 8'h00);
        wr(8'h03);
        idle(4);
        chk("R3 window expired", reg_rdata, 8'h00);
        strobe();
        chk("R3 late strobe ignored", flash_cmd, 4'h0);
    endtask

    task automatic t_abort();
        wr(8'h10);
        chk("R10 discard pulse", buf_discard, 1'b1);
        tick();
        chk("R10 pulse one cycle", buf_discard, 1'b0);
        wr(8'h10);
        chk("R10 empty buffer no pulse", buf_discard, 1'b0);
    endtask

    task automatic t_erase();
        gie = 1'b1;
        wr(8'h83);
        strobe();
        chk("R5 erase code", flash_cmd, 4'b0010);
        chk("R7 busy set", reg_rdata[6], 1'b1);
        chk("R7 read blocked", rww_rd_grant, 1'b0);
        chk("R11 irq low while enabled", irq, 1'b0);
        idle(2);
        chk("R5 held until busy", flash_cmd, 4'b0010);
        wr(8'h91);
        chk("R6 write ignored", reg_rdata, 8'hC3);
        flash_busy = 1'b1;
        tick();
        chk("R5 cmd drops", flash_cmd, 4'h0);
        chk("R6 enable held", reg_rdata[0], 1'b1);
        wr(8'h91);
        strobe();
        flash_busy = 1'b0;
        tick();
        chk("R6 bits cleared", reg_rdata[4:0], 5'h00);
        chk("R6 reenable refused", reg_rdata[6], 1'b1);
        chk("R11 ready irq", irq, 1'b1);
        gie = 1'b0;
        tick();
        chk("R11 gie gates", irq, 1'b0);
    endtask

    task automatic t_reenable();
        wr(8'h11);
        chk("R10 no pulse without data", buf_discard, 1'b0);
        strobe();
        chk("R8 busy cleared", reg_rdata, 8'h00);
        chk("R8 no flash cmd", flash_cmd, 4'h0);
        chk("R7 read granted", rww_rd_grant, 1'b1);
    endtask

    task automatic t_load_clears();
        wr(8'h03);
        strobe();
        ack();
        chk("R7 busy after erase", reg_rdata[6], 1'b1);
        wr(8'h01);
        strobe();
        chk("R9 load clears busy", reg_rdata[6], 1'b0);
        chk("R9 load code", flash_cmd, 4'b0001);
        ack();
    endtask

    task automatic t_lock_write();
        wr(8'h09);
        strobe();
        chk("R5 lock code", flash_cmd, 4'b1000);
        chk("R7 lock leaves busy", reg_rdata[6], 1'b0);
        ack();
        wr(8'h05);
        strobe();
        chk("R5 write code", flash_cmd, 4'b0100);
        chk("R7 write sets busy", reg_rdata[6], 1'b1);
        ack();
        wr(8'h10);
        chk("R10 buffer emptied by write", buf_discard, 1'b0);
        wr(8'h11);
        strobe();
        chk("R8 busy cleared after write", reg_rdata[6], 1'b0);
    endtask

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_layout();
        t_invalid();
        t_window();
        t_abort();
        t_erase();
        t_reenable();
        t_load_clears();
        t_lock_write();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule